// File: doc/BRIEF.md
# ATM Cell Payload Descrambler

This block sits on the receive byte path of an ATM cell stream, after cell delineation and before the cell store. It removes the x^43+1 self-synchronizing scrambling from the 48 payload octets of each cell, eight bits per clock. The five header octets are passed on exactly as received. A 43-bit history of received payload bits is kept from one cell to the next. This history freezes while header octets, idle cycles or bytes outside a cell go by, so the payload bit stream is treated as one unbroken sequence.

The upstream delineation logic supplies a start-of-cell marker on the first header octet and the current delineation state. Descrambling is applied only when the enable input is high and the delineation state is PRESYNC or SYNC. In every other case the data leaves unchanged, but the history keeps loading payload bits. Every valid byte leaves one clock after it enters, with its valid and start-of-cell flags delayed to match.

The byte position is tracked by a three-state machine. In WAIT the block is outside a cell. In HDR it is counting header octets. In PAY it is counting payload octets. A valid byte carrying the start-of-cell marker moves any state to HDR, and that byte is header octet 0. After header octet 4, HDR moves to PAY. After payload octet 47, PAY moves to WAIT. Cycles without a valid byte change neither the state nor the count.

Top module: `cell_payload_descrambler`

## Requirements
- R1: `out_valid` and `out_soc` equal `in_valid` and `in_soc` of the previous clock, and every valid byte appears on `out_data` exactly one clock after it is presented.
- R2: The valid byte marked with `in_soc` and the next four valid bytes are header octets and leave unchanged.
- R3: When descrambling is active, each payload output bit equals the received bit XORed with the received payload bit 43 positions earlier in the payload bit stream. Bit 7 of each byte is the earliest bit of that byte in the stream.
- R4: The 43-bit history is loaded only with received (still scrambled) payload bits. It holds its value across header octets, idle cycles and bytes outside a cell.
- R5: With `dsc_en` low, payload bytes leave unchanged, and the history still loads them.
- R6: `delin_state` is encoded as 0 = HUNT, 1 = PRESYNC, 2 = SYNC, 3 = reserved (treated like HUNT). Descrambling is active only for 1 and 2. Otherwise payload bytes leave unchanged, and the history still loads them.
- R7: After the 48th payload octet, valid bytes without `in_soc` are outside any cell. They leave unchanged and do not enter the history until the next `in_soc`.
- R8: An `in_soc` arriving in the middle of a cell abandons the current cell and restarts the header count with that byte as header octet 0.
- R9: Reset clears `out_valid`, `out_soc`, `out_data` and the history. The first 43 payload bits after reset are therefore XORed with zero.
- R10: A cycle with `in_valid` low gives `out_valid` low on the next clock and does not advance the byte position or the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present on `in_data` |
| in_soc | input | 1 | Marks header octet 0 of a cell |
| in_data | input | 8 | Received byte, bit 7 earliest on the line |
| dsc_en | input | 1 | Descrambling enable |
| delin_state | input | 2 | Delineation state: 0 HUNT, 1 PRESYNC, 2 SYNC, 3 reserved |
| out_valid | output | 1 | Delayed `in_valid` |
| out_soc | output | 1 | Delayed `in_soc` |
| out_data | output | 8 | Descrambled or passed-through byte |

## Verification
Directed cells in SYNC check the payload XOR against a bit-serial model. The payload contents are chosen so that a wrong tap, a wrong bit order or a history loaded from header bytes each give a different byte from the expected one. Cells with idle gaps and stray bytes between cells show whether the history freezes or drifts during non-payload bytes. Cells sent with the enable low or in HUNT and the reserved state show that the data passes through while the history still advances: the next active cell comes out wrong if the history did not load. A start-of-cell in mid-payload and many constrained-random cells, mixing enable, state, gaps and extra bytes, cover the restart and the transitions between the byte positions.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [1:0] {
        DL_HUNT    = 2'd0,
        DL_PRESYNC = 2'd1,
        DL_SYNC    = 2'd2,
        DL_RSVD    = 2'd3
    } delin_e;

    typedef enum logic [1:0] {
        POS_WAIT = 2'd0,
        POS_HDR  = 2'd1,
        POS_PAY  = 2'd2
    } pos_e;

    function automatic logic delin_active(input logic [1:0] st);
        return (st == DL_PRESYNC) || (st == DL_SYNC);
    endfunction

endpackage

// File: rtl/cpd_pos_fsm.sv
module cpd_pos_fsm
    import cpd_pkg::*;
#(
    parameter int HDR_LEN = 5,
    parameter int PAY_LEN = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_soc,
    output logic is_hdr,
    output logic is_pay
);
    localparam int CNT_W = $clog2(PAY_LEN > HDR_LEN ? PAY_LEN : HDR_LEN);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAY_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_SECOND = CNT_W'(1);

    pos_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= POS_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (in_valid) begin
            if (in_soc) begin
                state_d = POS_HDR;
                cnt_d   = HDR_SECOND;
            end else begin
                unique case (state_q)
                    POS_WAIT: begin
                        state_d = POS_WAIT;
                    end
                    POS_HDR: begin
                        if (cnt_q == HDR_LAST) begin
                            state_d = POS_PAY;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    POS_PAY: begin
                        if (cnt_q == PAY_LAST) begin
                            state_d = POS_WAIT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_d = POS_WAIT;
                        cnt_d   = '0;
                    end
                endcase
            end
        end
    end

    // outputs: classification of the byte currently presented
    always_comb begin
        is_hdr = 1'b0;
        is_pay = 1'b0;
        if (in_valid) begin
            if (in_soc) begin
                is_hdr = 1'b1;
            end else begin
                unique case (state_q)
                    POS_WAIT: ;
                    POS_HDR:  is_hdr = 1'b1;
                    POS_PAY:  is_pay = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // R8: start-of-cell always restarts header counting
    p_soc_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |=> (state_q == POS_HDR && cnt_q == HDR_SECOND));

    // R2: header count never passes the header length
    p_hdr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == POS_HDR) |-> (cnt_q <= HDR_LAST));

    // R10: no valid byte, no movement
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_q) && $stable(cnt_q)));

    // R7: leaving the payload only after its last octet
    p_pay_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == POS_PAY && in_valid && !in_soc && cnt_q != PAY_LAST) |=> (state_q == POS_PAY));

endmodule

// File: rtl/cpd_core.sv
module cpd_core #(
    parameter int BYTE_W   = 8,
    parameter int HIST_LEN = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    localparam int CAT_W = HIST_LEN + BYTE_W;

    logic [HIST_LEN-1:0] hist_q;
    logic [CAT_W-1:0]    cat;
    logic [BYTE_W-1:0]   mask;
    logic [BYTE_W-1:0]   dout_d;

    // bit 0 of the history is the newest received payload bit;
    // cat orders the stream with higher index = earlier bit
    assign cat = {hist_q, din};

    for (genvar i = 0; i < BYTE_W; i++) begin : g_tap
        assign mask[i] = cat[i + HIST_LEN];
    end

    assign dout_d = active ? (din ^ mask) : din;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            dout   <= '0;
        end else begin
            dout <= dout_d;
            if (load) begin
                hist_q <= cat[HIST_LEN-1:0];
            end
        end
    end

    // R4: history frozen unless a payload byte is presented
    p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hist_q));

    // R5: inactive bytes leave unchanged
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (dout == $past(din)));

    // R4: history advances by one byte of received bits
    p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hist_q[BYTE_W-1:0] == $past(din)));

endmodule

// File: rtl/cell_payload_descrambler.sv
module cell_payload_descrambler
    import cpd_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int HIST_LEN = 43,
    parameter int HDR_LEN  = 5,
    parameter int PAY_LEN  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              dsc_en,
    input  logic [1:0]        delin_state,
    output logic              out_valid,
    output logic              out_soc,
    output logic [BYTE_W-1:0] out_data
);
    logic is_hdr;
    logic is_pay;
    logic dsc_active;

    cpd_pos_fsm #(
        .HDR_LEN (HDR_LEN),
        .PAY_LEN (PAY_LEN)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_soc   (in_soc),
        .is_hdr   (is_hdr),
        .is_pay   (is_pay)
    );

    assign dsc_active = is_pay && dsc_en && delin_active(delin_state);

    cpd_core #(
        .BYTE_W   (BYTE_W),
        .HIST_LEN (HIST_LEN)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (is_pay),
        .active (dsc_active),
        .din    (in_data),
        .dout   (out_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
        end
    end

    // R1: flags follow their inputs by one clock
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R2: header octets pass unchanged
    p_hdr_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_hdr |=> (out_data == $past(in_data)));

    // R6: outside PRESYNC/SYNC nothing is altered
    p_state_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !delin_active(delin_state)) |=> (out_data == $past(in_data)));

    // R10: no byte in, no byte out
    p_no_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: a byte is never both header and payload
    p_class_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_hdr && is_pay));

endmodule

// File: tb/cell_payload_descrambler_test.sv
module cell_payload_descrambler_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_soc;
    logic [7:0] in_data;
    logic       dsc_en;
    logic [1:0] delin_state;
    logic       out_valid;
    logic       out_soc;
    logic [7:0] out_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // bench model state
    logic [42:0] m_hist;
    int          m_pos;   // 0 outside, 1 header, 2 payload
    int          m_cnt;

    always #10 clk = ~clk;   // 50 MHz

    cell_payload_descrambler uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_soc      (in_soc),
        .in_data     (in_data),
        .dsc_en      (dsc_en),
        .delin_state (delin_state),
        .out_valid   (out_valid),
        .out_soc     (out_soc),
        .out_data    (out_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] serial_descramble(input logic [7:0] d, input logic act);
        logic [7:0] r;
        for (int k = 7; k >= 0; k--) begin
            r[k]   = act ? (d[k] ^ m_hist[42]) : d[k];
            m_hist = {m_hist[41:0], d[k]};
        end
        return r;
    endfunction

    // computes the expected byte and the requirement it exercises
    task automatic model(input logic soc, input logic [7:0] d, input logic en, input logic [1:0] st,
                         output logic [7:0] exp, output string tag);
        logic act;
        act = en && (st == 2'd1 || st == 2'd2);
        if (soc) begin
            exp = d; tag = "R2"; m_pos = 1; m_cnt = 1;
        end else if (m_pos == 1) begin
            exp = d; tag = "R2";
            if (m_cnt == 4) begin m_pos = 2; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end else if (m_pos == 2) begin
            exp = serial_descramble(d, act);
            tag = !en ? "R5" : (!act ? "R6" : "R3,R4");
            if (m_cnt == 47) begin m_pos = 0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end else begin
            exp = d; tag = "R7";
        end
    endtask

    task automatic send(input logic v, input logic soc, input logic [7:0] d,
                        input logic en, input logic [1:0] st);
        logic [7:0] exp;
        string      tag;
        @(negedge clk);
        in_valid = v; in_soc = soc; in_data = d; dsc_en = en; delin_state = st;
        exp = 8'h00; tag = "R10";
        if (v) model(soc, d, en, st, exp, tag);
        @(posedge clk);
        #2;
        chk(out_valid == v, v ? "R1 valid" : "R10 valid", {7'd0, out_valid}, {7'd0, v});
        if (v) begin
            chk(out_soc == soc, "R1 soc", {7'd0, out_soc}, {7'd0, soc});
            chk(out_data == exp, tag, out_data, exp);
        end
    endtask

    task automatic send_cell(input logic en, input logic [1:0] st, input int gap_pct,
                             input logic [7:0] seed_byte);
        for (int b = 0; b < 53; b++) begin
            while (gap_pct > 0 && ($urandom % 100) < gap_pct)
                send(1'b0, 1'b0, 8'hA5, en, st);
            send(1'b1, b == 0, (seed_byte == 8'h00) ? 8'($urandom) : 8'(seed_byte + b * 37),
                 en, st);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_soc = 1'b0; in_data = 8'h00;
        dsc_en = 1'b1; delin_state = 2'd2;
        m_hist = '0; m_pos = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid == 1'b0, "R9 valid", {7'd0, out_valid}, 8'h00);
        chk(out_soc == 1'b0, "R9 soc", {7'd0, out_soc}, 8'h00);
        chk(out_data == 8'h00, "R9 data", out_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: first cell after reset, history zero, SYNC
        send_cell(1'b1, 2'd2, 0, 8'h11);
        // R3 R4: second cell uses history carried across header
        send_cell(1'b1, 2'd1, 0, 8'h5C);
        // R10: idle gaps inside a cell
        send_cell(1'b1, 2'd2, 30, 8'h3D);
        // R7: stray bytes outside a cell
        for (int i = 0; i < 6; i++) send(1'b1, 1'b0, 8'(8'hF0 + i), 1'b1, 2'd2);
        send_cell(1'b1, 2'd2, 0, 8'h77);
        // R5: enable low, history still loads
        send_cell(1'b0, 2'd2, 0, 8'h29);
        send_cell(1'b1, 2'd2, 0, 8'h81);
        // R6: HUNT and reserved state
        send_cell(1'b1, 2'd0, 0, 8'h4B);
        send_cell(1'b1, 2'd3, 0, 8'hC6);
        send_cell(1'b1, 2'd2, 0, 8'h92);
        // R8: start-of-cell inside the payload
        for (int b = 0; b < 20; b++) send(1'b1, b == 0, 8'(8'h13 * b + 1), 1'b1, 2'd2);
        send_cell(1'b1, 2'd2, 0, 8'hE4);

        // constrained random cells
        for (int c = 0; c < 250; c++) begin
            send_cell(($urandom % 4) != 0, 2'($urandom % 4), ($urandom % 2) ? 12 : 0, 8'h00);
            if (($urandom % 5) == 0) begin
                for (int x = 0; x < int'($urandom % 4) + 1; x++)
                    send(1'b1, 1'b0, 8'($urandom), 1'b1, 2'd2);
            end
            if (($urandom % 10) == 0) begin
                for (int x = 0; x < int'($urandom % 30) + 1; x++)
                    send(1'b1, x == 0, 8'($urandom), 1'b1, 2'd2);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule